// File: doc/BRIEF.md
# DDR2 Power-Up Command Sequencer

This block walks a set of DDR2 memory ranks from power-up to normal operation. After a `start` pulse it issues a fixed series of initialisation steps. The steps are a no-operation, a long settling wait, precharge-all, a mode-register write that resets the DLL, a second precharge-all, a burst of refresh cycles, a mode-register write that carries the computed operating mode, and two normal-operation commands. Each step goes out first at base address zero. It is then repeated for every rank whose start value is nonzero, ascending by rank index. A rank's base address is its 8-bit start value shifted left by 26.

Every access leaves the block as a command code plus a 34-bit address on a valid/ready handshake. The command code also appears in the low three bits of a control byte whose upper five bits pass through from an input. The operating-mode word is built from the burst length, CAS latency and write-recovery settings captured at `start`, and it travels as the address offset of the final mode step. All waits are counted in clock cycles from the `CYC_PER_US` parameter. When the last access is accepted, the refresh counter output is loaded with 0x32 and `done` pulses for one cycle.

The controller states are Idle, Issue (an access is offered), Gap (refresh spacing), Delay (200 µs settling) and Finish (done pulse). The transitions are: Idle→Issue on `start`. Issue→Issue on acceptance of a non-refresh access while more remain. Issue→Gap on acceptance of a refresh access. Gap→Issue when the spacing expires. Issue→Delay when the last no-operation access is accepted. Delay→Issue when the settling time expires. Issue→Finish when the final normal-operation access is accepted. Finish→Idle after one cycle.

Top module: `ddr2_init_seq`

## Requirements
- R1: After reset `cmd_valid` and `done` are 0, `refresh_cnt` is 0 and `cmd_code` is 0.
- R2: Steps run in this order with these codes: no-op (1), precharge (2), mode write with DLL reset (3), precharge (2), refresh (4), mode write with operating mode (3), normal at offset 0 (0), normal at offset 0x30 (0).
- R3: Each step is issued first with base 0, then once per rank with a nonzero start value, in ascending rank order. Rank i occupies bits [8i+7:8i] of `rank_start`, and `cmd_addr` = (start << 26) + offset.
- R4: `ctl_byte` equals {`ctl_hi`, `cmd_code`} for every access.
- R5: In each pass the DLL-reset mode step makes two accesses, at offset 0x12000 and then 0x800.
- R6: In each pass the operating-mode step makes three accesses, at the mode word, then 0x121C20, then 0x120020.
- R7: The mode word is the sum of three terms, using values captured at the accepted `start`. The first is 8 when `burst8` is 1. The second comes from `cas_sel` 0/1/2/3 (CL 2/3/4/5) as 0x150/0x1D0/0x250/0x2D0. The third comes from `wr_sel` 0/1/2/3 (WR 2/3/4/5) as 0x1000/0x100000/0x101000/0x2000.
- R8: The refresh step makes 8 accesses at offset 0 per pass. With `cmd_ready` held high, each refresh access is followed by the next offer exactly 10×`CYC_PER_US` cycles later on the base pass and 100×`CYC_PER_US` cycles later on rank passes.
- R9: With `cmd_ready` held high, the first precharge is offered exactly 200×`CYC_PER_US` cycles after the last no-op access is accepted. Other accesses follow one cycle after the previous acceptance.
- R10: While `cmd_valid` is high and `cmd_ready` low, the code and address hold steady.
- R11: `refresh_cnt` clears to 0 on an accepted `start`. It reads 0x32 from the cycle in which `done` pulses, and `done` is high for exactly one cycle with `cmd_valid` low afterwards.
- R12: A `start` while a sequence runs has no effect on the access stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sequence (accepted only when idle) |
| ctl_hi | input | 5 | Upper control-byte bits, passed through |
| burst8 | input | 1 | 1 = burst length 8, 0 = burst length 4 |
| cas_sel | input | 2 | CAS latency select (CL = 2 + value) |
| wr_sel | input | 2 | Write-recovery select (WR = 2 + value) |
| rank_start | input | NUM_RANKS*8 | Per-rank start values, 0 = rank absent |
| cmd_ready | input | 1 | Downstream accepts the current access |
| cmd_valid | output | 1 | An access is offered |
| cmd_code | output | 3 | Command code of the offered access |
| ctl_byte | output | 8 | {ctl_hi, cmd_code} |
| cmd_addr | output | 34 | Access address |
| refresh_cnt | output | 8 | Refresh counter value |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The checks assume that `rank_start` stays constant from an accepted `start` until `done`, because the pass scan reads it live. They also assume that `cmd_ready` is driven to a defined level every cycle. The stimulus changes rank configurations only while the block is idle. It changes the mode settings only after `start` has been taken, which also exercises capture. Backpressure is produced by a pseudo-random pattern applied a short time after each clock edge. Exact cycle spacing is compared only in runs where `cmd_ready` is held high.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

    typedef enum logic [2:0] {
        CMD_NORMAL    = 3'd0,
        CMD_NOP       = 3'd1,
        CMD_PRECHARGE = 3'd2,
        CMD_MODE      = 3'd3,
        CMD_REFRESH   = 3'd4
    } cmd_e;

    typedef enum logic [3:0] {
        STEP_NOP,
        STEP_PRE_A,
        STEP_MODE_DLL,
        STEP_PRE_B,
        STEP_REFRESH,
        STEP_MODE_RUN,
        STEP_NORM_A,
        STEP_NORM_B
    } step_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_GAP,
        ST_DELAY,
        ST_FINISH
    } state_e;

    localparam int OFS_W         = 24;
    localparam int ACC_W         = 3;
    localparam logic [OFS_W-1:0] OFS_DLL_MODE = 24'h012000;
    localparam logic [OFS_W-1:0] OFS_DLL_RST  = 24'h000800;
    localparam logic [OFS_W-1:0] OFS_OCD_DEF  = 24'h121C20;
    localparam logic [OFS_W-1:0] OFS_OCD_EXIT = 24'h120020;
    localparam logic [OFS_W-1:0] OFS_NORM_HI  = 24'h000030;
    localparam int REFRESH_REPS  = 8;

    function automatic cmd_e step_cmd(input step_e s);
        cmd_e c;
        unique case (s)
            STEP_NOP:                c = CMD_NOP;
            STEP_PRE_A, STEP_PRE_B:  c = CMD_PRECHARGE;
            STEP_MODE_DLL,
            STEP_MODE_RUN:           c = CMD_MODE;
            STEP_REFRESH:            c = CMD_REFRESH;
            default:                 c = CMD_NORMAL;
        endcase
        return c;
    endfunction

    function automatic logic [ACC_W-1:0] step_last_acc(input step_e s);
        logic [ACC_W-1:0] n;
        unique case (s)
            STEP_MODE_DLL: n = ACC_W'(1);
            STEP_MODE_RUN: n = ACC_W'(2);
            STEP_REFRESH:  n = ACC_W'(REFRESH_REPS - 1);
            default:       n = '0;
        endcase
        return n;
    endfunction

    function automatic step_e step_after(input step_e s);
        step_e n;
        unique case (s)
            STEP_NOP:      n = STEP_PRE_A;
            STEP_PRE_A:    n = STEP_MODE_DLL;
            STEP_MODE_DLL: n = STEP_PRE_B;
            STEP_PRE_B:    n = STEP_REFRESH;
            STEP_REFRESH:  n = STEP_MODE_RUN;
            STEP_MODE_RUN: n = STEP_NORM_A;
            STEP_NORM_A:   n = STEP_NORM_B;
            default:       n = STEP_NORM_B;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/ddr2_mode_calc.sv
module ddr2_mode_calc
    import ddr2_init_pkg::*;
(
    input  logic             burst8,
    input  logic [1:0]       cas_sel,
    input  logic [1:0]       wr_sel,
    output logic [OFS_W-1:0] mode_val
);

    logic [OFS_W-1:0] cas_term;
    logic [OFS_W-1:0] wr_term;
    logic [OFS_W-1:0] bl_term;

    always_comb begin
        unique case (cas_sel)
            2'd0: cas_term = 24'h000150;
            2'd1: cas_term = 24'h0001D0;
            2'd2: cas_term = 24'h000250;
            default: cas_term = 24'h0002D0;
        endcase
        unique case (wr_sel)
            2'd0: wr_term = 24'h001000;
            2'd1: wr_term = 24'h100000;
            2'd2: wr_term = 24'h101000;
            default: wr_term = 24'h002000;
        endcase
        bl_term  = burst8 ? 24'h000008 : 24'h000000;
        mode_val = cas_term + wr_term + bl_term;
    end

endmodule

// File: rtl/ddr2_rank_scan.sv
module ddr2_rank_scan #(
    parameter int NUM_RANKS = 4,
    parameter int START_W   = 8,
    parameter int PASS_W    = 3
) (
    input  logic [NUM_RANKS*START_W-1:0] rank_start,
    input  logic [PASS_W-1:0]            cur_pass,
    output logic [PASS_W-1:0]            next_pass,
    output logic                         next_ok,
    output logic [START_W-1:0]           cur_start
);

    logic [NUM_RANKS-1:0] populated;

    for (genvar g = 0; g < NUM_RANKS; g++) begin : g_pop
        assign populated[g] = |rank_start[g*START_W +: START_W];
    end

    always_comb begin
        next_ok   = 1'b0;
        next_pass = '0;
        for (int p = NUM_RANKS; p >= 1; p--) begin
            if ((PASS_W'(p) > cur_pass) && populated[p-1]) begin
                next_ok   = 1'b1;
                next_pass = PASS_W'(p);
            end
        end
    end

    always_comb begin
        cur_start = '0;
        for (int p = 1; p <= NUM_RANKS; p++) begin
            if (cur_pass == PASS_W'(p)) begin
                cur_start = rank_start[(p-1)*START_W +: START_W];
            end
        end
    end

endmodule

// File: rtl/ddr2_wait_timer.sv
module ddr2_wait_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign expired = (cnt <= CNT_W'(1));

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
    import ddr2_init_pkg::*;
#(
    parameter int          NUM_RANKS    = 4,
    parameter int          START_W      = 8,
    parameter int          RANK_SHIFT   = 26,
    parameter int          CYC_PER_US   = 50,
    parameter int          REFRESH_W    = 8,
    parameter logic [7:0]  REFRESH_LOAD = 8'h32,
    localparam int         ADDR_W       = START_W + RANK_SHIFT
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [4:0]                   ctl_hi,
    input  logic                         burst8,
    input  logic [1:0]                   cas_sel,
    input  logic [1:0]                   wr_sel,
    input  logic [NUM_RANKS*START_W-1:0] rank_start,
    input  logic                         cmd_ready,
    output logic                         cmd_valid,
    output logic [2:0]                   cmd_code,
    output logic [7:0]                   ctl_byte,
    output logic [ADDR_W-1:0]            cmd_addr,
    output logic [REFRESH_W-1:0]         refresh_cnt,
    output logic                         done
);

    localparam int PASS_W     = $clog2(NUM_RANKS + 1);
    localparam int DELAY_CYC  = 200 * CYC_PER_US;
    localparam int GAP_FIRST  = 10 * CYC_PER_US;
    localparam int GAP_RANK   = 100 * CYC_PER_US;
    localparam int CNT_W      = $clog2(DELAY_CYC + 1);

    state_e              state_q, state_n;
    step_e               step_q, step_n;
    logic [PASS_W-1:0]   pass_q, pass_n;
    logic [ACC_W-1:0]    acc_q, acc_n;
    logic                bl8_q;
    logic [1:0]          cas_q, wr_q;
    logic [REFRESH_W-1:0] refresh_q;

    logic                take_start;
    logic                advance;
    logic                ref_set;
    logic                tmr_load;
    logic [CNT_W-1:0]    tmr_val;
    logic                tmr_expired;

    logic [PASS_W-1:0]   next_pass;
    logic                next_ok;
    logic [START_W-1:0]  cur_start;
    logic [OFS_W-1:0]    mode_val;
    logic [OFS_W-1:0]    offset;

    ddr2_mode_calc u_mode (
        .burst8   (bl8_q),
        .cas_sel  (cas_q),
        .wr_sel   (wr_q),
        .mode_val (mode_val)
    );

    ddr2_rank_scan #(
        .NUM_RANKS (NUM_RANKS),
        .START_W   (START_W),
        .PASS_W    (PASS_W)
    ) u_scan (
        .rank_start (rank_start),
        .cur_pass   (pass_q),
        .next_pass  (next_pass),
        .next_ok    (next_ok),
        .cur_start  (cur_start)
    );

    ddr2_wait_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    // State and sequencing registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            step_q    <= STEP_NORM_B;
            pass_q    <= '0;
            acc_q     <= '0;
            bl8_q     <= 1'b0;
            cas_q     <= '0;
            wr_q      <= '0;
            refresh_q <= '0;
        end else begin
            state_q <= state_n;
            step_q  <= step_n;
            pass_q  <= pass_n;
            acc_q   <= acc_n;
            if (take_start) begin
                bl8_q     <= burst8;
                cas_q     <= cas_sel;
                wr_q      <= wr_sel;
                refresh_q <= '0;
            end else if (ref_set) begin
                refresh_q <= REFRESH_W'(REFRESH_LOAD);
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_n    = state_q;
        step_n     = step_q;
        pass_n     = pass_q;
        acc_n      = acc_q;
        take_start = 1'b0;
        advance    = 1'b0;
        ref_set    = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;

        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    take_start = 1'b1;
                    state_n    = ST_ISSUE;
                    step_n     = STEP_NOP;
                    pass_n     = '0;
                    acc_n      = '0;
                end
            end
            ST_ISSUE: begin
                if (cmd_ready) begin
                    if (step_q == STEP_REFRESH) begin
                        tmr_load = 1'b1;
                        tmr_val  = (pass_q == '0) ? CNT_W'(GAP_FIRST - 1)
                                                  : CNT_W'(GAP_RANK - 1);
                        state_n  = ST_GAP;
                    end else begin
                        advance = 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (tmr_expired) begin
                    advance = 1'b1;
                end
            end
            ST_DELAY: begin
                if (tmr_expired) begin
                    state_n = ST_ISSUE;
                    step_n  = STEP_PRE_A;
                    pass_n  = '0;
                    acc_n   = '0;
                end
            end
            ST_FINISH: begin
                state_n = ST_IDLE;
            end
            default: begin
                state_n = ST_IDLE;
            end
        endcase

        if (advance) begin
            if (acc_q != step_last_acc(step_q)) begin
                acc_n   = acc_q + ACC_W'(1);
                state_n = ST_ISSUE;
            end else if (next_ok) begin
                pass_n  = next_pass;
                acc_n   = '0;
                state_n = ST_ISSUE;
            end else if (step_q == STEP_NOP) begin
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(DELAY_CYC - 1);
                state_n  = ST_DELAY;
            end else if (step_q == STEP_NORM_B) begin
                ref_set = 1'b1;
                state_n = ST_FINISH;
            end else begin
                step_n  = step_after(step_q);
                pass_n  = '0;
                acc_n   = '0;
                state_n = ST_ISSUE;
            end
        end
    end

    // Outputs
    always_comb begin
        unique case (step_q)
            STEP_MODE_DLL: offset = (acc_q == '0) ? OFS_DLL_MODE : OFS_DLL_RST;
            STEP_MODE_RUN: begin
                if (acc_q == '0)              offset = mode_val;
                else if (acc_q == ACC_W'(1))  offset = OFS_OCD_DEF;
                else                          offset = OFS_OCD_EXIT;
            end
            STEP_NORM_B:   offset = OFS_NORM_HI;
            default:       offset = '0;
        endcase
        cmd_valid   = (state_q == ST_ISSUE);
        done        = (state_q == ST_FINISH);
        cmd_code    = step_cmd(step_q);
        ctl_byte    = {ctl_hi, cmd_code};
        cmd_addr    = {cur_start, {RANK_SHIFT{1'b0}}} + ADDR_W'(offset);
        refresh_cnt = refresh_q;
    end

endmodule

// File: rtl/ddr2_init_seq_chk.sv
module ddr2_init_seq_chk #(
    parameter int ADDR_W    = 34,
    parameter int REFRESH_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_valid,
    input logic                 cmd_ready,
    input logic [2:0]           cmd_code,
    input logic [ADDR_W-1:0]    cmd_addr,
    input logic [REFRESH_W-1:0] refresh_cnt,
    input logic                 done
);

    // R10: offered access is held while stalled
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_code)));

    // R11: done is a single-cycle pulse
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: refresh counter is loaded when done pulses
    p_refresh_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (refresh_cnt == REFRESH_W'(8'h32)));

    // R11: nothing is offered after done
    p_quiet_after_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !cmd_valid);

    // R2: only defined command codes are offered
    p_code_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_code <= 3'd4));

endmodule

bind ddr2_init_seq ddr2_init_seq_chk #(
    .ADDR_W    (ADDR_W),
    .REFRESH_W (REFRESH_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_code    (cmd_code),
    .cmd_addr    (cmd_addr),
    .refresh_cnt (refresh_cnt),
    .done        (done)
);

// File: tb/tb_ddr2_init_seq.sv
module tb_ddr2_init_seq;

    localparam int NR   = 4;
    localparam int CPU  = 2;
    localparam int AW   = 34;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [4:0]    ctl_hi = 5'h00;
    logic          burst8 = 1'b0;
    logic [1:0]    cas_sel = 2'd0;
    logic [1:0]    wr_sel = 2'd0;
    logic [NR*8-1:0] rank_start = '0;
    logic          cmd_ready = 1'b1;
    logic          cmd_valid;
    logic [2:0]    cmd_code;
    logic [7:0]    ctl_byte;
    logic [AW-1:0] cmd_addr;
    logic [7:0]    refresh_cnt;
    logic          done;

    ddr2_init_seq #(.NUM_RANKS(NR), .CYC_PER_US(CPU)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ctl_hi(ctl_hi),
        .burst8(burst8), .cas_sel(cas_sel), .wr_sel(wr_sel),
        .rank_start(rank_start), .cmd_ready(cmd_ready),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .ctl_byte(ctl_byte),
        .cmd_addr(cmd_addr), .refresh_cnt(refresh_cnt), .done(done)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic [2:0]    code;
        logic [AW-1:0] addr;
        int            gap;
    } item_t;

    item_t exp_q[$];
    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int last_acc_cyc = 0;
    bit bp_mode = 1'b0;
    logic [7:0] lfsr = 8'hA5;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        #2;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        cmd_ready = bp_mode ? lfsr[0] : 1'b1;
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && cmd_valid && cmd_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R12 unexpected access", longint'(cmd_addr), 0);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                check(cmd_code == e.code, "R2 code", longint'(cmd_code), longint'(e.code));
                check(cmd_addr == e.addr, "R3 addr", longint'(cmd_addr), longint'(e.addr));
                check(ctl_byte == {ctl_hi, e.code}, "R4 ctl_byte",
                      longint'(ctl_byte), longint'({ctl_hi, e.code}));
                if (!bp_mode && e.gap != 0)
                    check((cyc - last_acc_cyc) == e.gap, "R8 R9 spacing",
                          longint'(cyc - last_acc_cyc), longint'(e.gap));
            end
            last_acc_cyc = cyc;
        end
    end

    function automatic logic [23:0] exp_mode(input logic b8, input logic [1:0] c, input logic [1:0] w);
        logic [23:0] m;
        m = b8 ? 24'h8 : 24'h0;
        case (c)
            2'd0: m = m + 24'h150;
            2'd1: m = m + 24'h1D0;
            2'd2: m = m + 24'h250;
            default: m = m + 24'h2D0;
        endcase
        case (w)
            2'd0: m = m + 24'h1000;
            2'd1: m = m + 24'h100000;
            2'd2: m = m + 24'h101000;
            default: m = m + 24'h2000;
        endcase
        return m;
    endfunction

    // Driver: build expected access stream (R2, R3, R5, R6, R7, R8, R9)
    task automatic build_expected(input logic [NR*8-1:0] rs, input logic [23:0] mode);
        int prev_wait;
        logic [2:0] codes [8];
        codes = '{3'd1, 3'd2, 3'd3, 3'd2, 3'd4, 3'd3, 3'd0, 3'd0};
        prev_wait = 0;
        for (int s = 0; s < 8; s++) begin
            for (int p = 0; p <= NR; p++) begin
                logic [AW-1:0] base;
                logic [23:0] ofs [8];
                int n;
                if (p > 0 && rs[(p-1)*8 +: 8] == 8'h00) continue;
                base = (p == 0) ? '0 : {rs[(p-1)*8 +: 8], 26'h0};
                n = 1;
                ofs[0] = 24'h0;
                if (s == 2) begin n = 2; ofs[0] = 24'h12000; ofs[1] = 24'h800; end
                if (s == 4) begin n = 8; for (int k = 0; k < 8; k++) ofs[k] = 24'h0; end
                if (s == 5) begin n = 3; ofs[0] = mode; ofs[1] = 24'h121C20; ofs[2] = 24'h120020; end
                if (s == 7) ofs[0] = 24'h30;
                for (int k = 0; k < n; k++) begin
                    item_t it;
                    it.code = codes[s];
                    it.addr = base + AW'(ofs[k]);
                    it.gap  = prev_wait;
                    exp_q.push_back(it);
                    prev_wait = (s == 4) ? ((p == 0) ? 10*CPU : 100*CPU) : 1;
                end
            end
            if (s == 0) prev_wait = 200*CPU;
        end
    endtask

    task automatic run_seq(input logic [NR*8-1:0] rs, input logic b8, input logic [1:0] c,
                           input logic [1:0] w, input logic [4:0] hi, input bit bp,
                           input bit scramble, input bit restart);
        int wd;
        @(negedge clk);
        rank_start = rs; burst8 = b8; cas_sel = c; wr_sel = w; ctl_hi = hi;
        bp_mode = bp;
        build_expected(rs, exp_mode(b8, c, w));
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(refresh_cnt == 8'h00, "R11 refresh cleared on start", longint'(refresh_cnt), 0);
        if (scramble) begin
            // R7: settings are captured at start; later changes have no effect
            burst8 = ~b8; cas_sel = c + 2'd1; wr_sel = w + 2'd2;
        end
        wd = 0;
        while (!done && wd < 60000) begin
            @(negedge clk);
            wd++;
            if (restart && wd == 50) start = 1'b1;   // R12
            if (restart && wd == 51) start = 1'b0;
        end
        check(done == 1'b1, "R11 done reached", longint'(done), 1);
        check(refresh_cnt == 8'h32, "R11 refresh loaded", longint'(refresh_cnt), 32'h32);
        check(exp_q.size() == 0, "R12 R2 stream complete", exp_q.size(), 0);
        @(negedge clk);
        check(done == 1'b0, "R11 done one cycle", longint'(done), 0);
        check(cmd_valid == 1'b0, "R11 idle after done", longint'(cmd_valid), 0);
        exp_q.delete();
        bp_mode = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(cmd_valid == 1'b0, "R1 valid", longint'(cmd_valid), 0);
        check(done == 1'b0, "R1 done", longint'(done), 0);
        check(refresh_cnt == 8'h00, "R1 refresh", longint'(refresh_cnt), 0);
        check(cmd_code == 3'd0, "R1 code", longint'(cmd_code), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Ranks 1 and 3 populated, BL8 CL3 WR4, settings scrambled after start (R7)
        run_seq(32'h05_00_02_00, 1'b1, 2'd1, 2'd2, 5'h15, 1'b0, 1'b1, 1'b0);
        // No ranks: base pass only, BL4 CL2 WR2, backpressure (R10)
        run_seq(32'h00_00_00_00, 1'b0, 2'd0, 2'd0, 5'h0A, 1'b1, 1'b0, 1'b0);
        // All ranks, maximum start value, BL8 CL5 WR5, restart attempt (R12)
        run_seq(32'hFF_40_81_01, 1'b1, 2'd3, 2'd3, 5'h1F, 1'b0, 1'b0, 1'b1);
        // Only the last rank, CL4 WR3 with backpressure
        run_seq(32'h3C_00_00_00, 1'b0, 2'd2, 2'd1, 5'h11, 1'b1, 1'b0, 1'b0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule